// File: doc/BRIEF.md
# Per-Pixel Visual Colour Lookup

This block turns a stream of framebuffer words, one per pixel, into 8-bit red, green and blue values. Each pixel word carries its own 2-bit visual selector next to 24 colour bits. Pixels in one frame can therefore mix four visuals:
- an indexed visual, where one byte looks up all three palette channels;
- a per-channel direct visual, where each byte looks up its own palette channel;
- a gamma-corrected true-colour visual;
- a raw true-colour visual.

Pixels enter with a valid strobe at up to one per clock and leave two clocks later with a matching valid strobe.

Software loads the colour tables through a small 32-bit register port. A write to the address register selects a table index. Data accesses then walk through red, green and blue in that order and move to the next index after blue. The palette has 256 entries and 4 extra overlay entries, and the overlay entries share the index register. The gamma table is a single 256-entry channel that is shared by all three colour bytes. It uses the same index and moves to the next index on every access. Reads use the same ordering as writes and return the selected byte in the top byte of the read word.

Top module: `visual_lut`

## Requirements
- R1: A pixel word has the visual selector in bits [25:24] and colour bytes c0 = [7:0], c1 = [15:8], c2 = [23:16]. Outputs are red, green and blue.
- R2: Selector 00 gives red = palR[c0], green = palG[c0], blue = palB[c0].
- R3: Selector 01 gives red = palR[c0], green = palG[c1], blue = palB[c2].
- R4: Selector 11 gives red = c0, green = c1, blue = c2, unchanged.
- R5: Selector 10 gives red = gam[c0], green = gam[c1], blue = gam[c2]. A gamma entry that has not been written since reset returns its own index.
- R6: Every valid input pixel produces exactly one valid output two clocks later. Back-to-back pixels are accepted on every clock, and no output is valid without a matching input.
- R7: A write to offset 0 sets the index to wdata[31:24] and returns the channel step to red, even in the middle of a sequence.
- R8: Writes to offset 4 store wdata[31:24] into the red, then green, then blue palette entry at the index. After blue the index advances modulo 256, so 255 wraps to 0.
- R9: Writes to offset 12 use the same red, green, blue step but target overlay entry (index & 3). The shared index still advances after blue, and the palette is left unchanged.
- R10: A write to offset 8 stores wdata[31:24] into gam[index] and advances the index. The channel step is left unchanged.
- R11: The read data is valid in the clock after a read strobe and then holds. Offset 0 returns the index in [31:24]. Offsets 4, 12 and 8 return the addressed byte in [31:24] with zero below it, and they step and advance the index exactly as writes do.
- R12: Writes to any other offset change no table and no index. Reads from any other offset return zero.
- R13: After reset, palette entry 255 and overlay entries 0 and 2 are white (FF in every channel), and every other palette and overlay entry is black. The index is 0, the step is red and no output is valid. A later reset restores these values.
- R14: A pixel sampled in the same clock as a table write sees the entry as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid_i | input | 1 | Input pixel strobe |
| pix_word_i | input | 26 | Selector and colour bytes |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (ignored while reg_wr_i is high) |
| reg_ofs_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| reg_rvalid_o | output | 1 | Read data strobe, one clock after a read |
| rgb_valid_o | output | 1 | Output pixel strobe |
| red_o | output | 8 | Red output |
| green_o | output | 8 | Green output |
| blue_o | output | 8 | Blue output |

## Verification
The bench builds the block with its default parameters: 8-bit channels, a 256-entry palette, four overlay entries, and overlay entries 0 and 2 white at reset. With these sizes the index can be loaded near the top of the table, so the wrap from 255 to 0 is reached within a few accesses. Each visual, the overlay aliasing through index & 3 and the write-versus-lookup collision are reached in short directed phases. A long mixed phase then interleaves random pixels with random register traffic, and a second reset confirms that previously written entries return to their power-up colours.

// File: rtl/vlut_pkg.sv
package vlut_pkg;

  // Register offsets; the low two bits are part of the decode.
  localparam int unsigned OFS_W = 4;
  localparam logic [OFS_W-1:0] OFS_INDEX = 4'd0;
  localparam logic [OFS_W-1:0] OFS_PAL   = 4'd4;
  localparam logic [OFS_W-1:0] OFS_GAM   = 4'd8;
  localparam logic [OFS_W-1:0] OFS_OVL   = 4'd12;

  // Number of colour channels per pixel.
  localparam int unsigned NCH = 3;

  typedef enum logic [1:0] {
    VIS_PSEUDO = 2'b00,
    VIS_DIRECT = 2'b01,
    VIS_GAMMA  = 2'b10,
    VIS_RAW    = 2'b11
  } visual_e;

  typedef enum logic [1:0] {
    SEQ_RED = 2'd0,
    SEQ_GRN = 2'd1,
    SEQ_BLU = 2'd2
  } seq_e;

  typedef enum logic [2:0] {
    RS_ZERO  = 3'd0,
    RS_INDEX = 3'd1,
    RS_PAL   = 3'd2,
    RS_GAM   = 3'd3,
    RS_OVL   = 3'd4
  } rsel_e;

endpackage

// File: rtl/vlut_table.sv
// One colour channel table: a RAM with one write/read port and one read
// port. A flag per entry marks entries written since reset. Unwritten
// entries return a computed default, so the RAM itself needs no reset.
module vlut_table #(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned W         = 8,
  parameter bit          IDENT_DEF = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] a_addr,
  input  logic [W-1:0]     wdata,
  input  logic             a_re,
  output logic [W-1:0]     a_q,
  input  logic [IDX_W-1:0] b_addr,
  output logic [W-1:0]     b_q
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] filled;
  logic [W-1:0]     a_raw;
  logic [W-1:0]     b_raw;
  logic             a_fill;
  logic             b_fill;
  logic [IDX_W-1:0] a_addr_q;
  logic [IDX_W-1:0] b_addr_q;

  // Plain RAM body, kept free of reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[a_addr] <= wdata;
    end
    if (a_re) begin
      a_raw <= mem[a_addr];
    end
    b_raw <= mem[b_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filled   <= '0;
      a_fill   <= 1'b0;
      b_fill   <= 1'b0;
      a_addr_q <= '0;
      b_addr_q <= '0;
    end else begin
      if (we) begin
        filled[a_addr] <= 1'b1;
      end
      if (a_re) begin
        a_fill   <= filled[a_addr];
        a_addr_q <= a_addr;
      end
      b_fill   <= filled[b_addr];
      b_addr_q <= b_addr;
    end
  end

  function automatic logic [W-1:0] dflt(input logic [IDX_W-1:0] i);
    if (IDENT_DEF) begin
      dflt = W'(i);
    end else begin
      dflt = (&i) ? '1 : '0;
    end
  endfunction

  assign a_q = a_fill ? a_raw : dflt(a_addr_q);
  assign b_q = b_fill ? b_raw : dflt(b_addr_q);

endmodule

// File: rtl/vlut_regif.sv
// Register port: index register, red/green/blue step, overlay entries,
// table write enables and read data selection.
module vlut_regif
  import vlut_pkg::*;
#(
  parameter int unsigned      CH_W      = 8,
  parameter int unsigned      DATA_W    = 32,
  parameter int unsigned      OVL_N     = 4,
  parameter logic [OVL_N-1:0] OVL_WHITE = 4'b0101
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [OFS_W-1:0]          ofs_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [CH_W-1:0]           idx_o,
  output logic [CH_W-1:0]           wbyte_o,
  output logic [NCH-1:0]            pal_we_o,
  output logic                      gam_we_o,
  output logic                      tab_re_o,
  input  logic [NCH-1:0][CH_W-1:0]  pal_q_i,
  input  logic [NCH-1:0][CH_W-1:0]  gam_q_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      rvalid_o
);

  localparam int unsigned OVL_W = (OVL_N > 1) ? $clog2(OVL_N) : 1;

  logic [CH_W-1:0]          idx_q;
  seq_e                     seq_q;
  logic [NCH-1:0][CH_W-1:0] ovl_q [OVL_N];
  rsel_e                    rsel_q;
  rsel_e                    rsel_d;
  seq_e                     rseq_q;
  logic [CH_W-1:0]          rovl_q;
  logic [CH_W-1:0]          ridx_q;
  logic                     rvalid_q;

  logic do_wr, do_rd;
  logic hit_idx, hit_pal, hit_gam, hit_ovl;
  logic step_rgb, step_gam;
  logic [OVL_W-1:0] ovl_sel;

  assign do_wr    = wr_i;
  assign do_rd    = rd_i & ~wr_i;
  assign hit_idx  = (ofs_i == OFS_INDEX);
  assign hit_pal  = (ofs_i == OFS_PAL);
  assign hit_gam  = (ofs_i == OFS_GAM);
  assign hit_ovl  = (ofs_i == OFS_OVL);
  assign step_rgb = (do_wr | do_rd) & (hit_pal | hit_ovl);
  assign step_gam = (do_wr | do_rd) & hit_gam;
  assign ovl_sel  = idx_q[OVL_W-1:0];

  assign wbyte_o  = wdata_i[DATA_W-1 -: CH_W];
  assign idx_o    = idx_q;
  assign tab_re_o = do_rd;
  assign gam_we_o = do_wr & hit_gam;
  assign pal_we_o = (do_wr & hit_pal) ? (NCH'(1) << seq_q) : '0;
  assign rvalid_o = rvalid_q;

  always_comb begin
    if (hit_idx)      rsel_d = RS_INDEX;
    else if (hit_pal) rsel_d = RS_PAL;
    else if (hit_gam) rsel_d = RS_GAM;
    else if (hit_ovl) rsel_d = RS_OVL;
    else              rsel_d = RS_ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      seq_q    <= SEQ_RED;
      rsel_q   <= RS_ZERO;
      rseq_q   <= SEQ_RED;
      rovl_q   <= '0;
      ridx_q   <= '0;
      rvalid_q <= 1'b0;
      for (int k = 0; k < OVL_N; k++) begin
        ovl_q[k] <= {(NCH*CH_W){OVL_WHITE[k]}};
      end
    end else begin
      rvalid_q <= do_rd;
      if (do_wr && hit_idx) begin
        idx_q <= wdata_i[DATA_W-1 -: CH_W];
        seq_q <= SEQ_RED;
      end else if (step_rgb) begin
        if (seq_q == SEQ_BLU) begin
          seq_q <= SEQ_RED;
          idx_q <= idx_q + 1'b1;
        end else begin
          seq_q <= seq_e'(seq_q + 2'd1);
        end
      end else if (step_gam) begin
        idx_q <= idx_q + 1'b1;
      end
      if (do_wr && hit_ovl) begin
        ovl_q[ovl_sel][seq_q] <= wdata_i[DATA_W-1 -: CH_W];
      end
      if (do_rd) begin
        rsel_q <= rsel_d;
        rseq_q <= seq_q;
        rovl_q <= ovl_q[ovl_sel][seq_q];
        ridx_q <= idx_q;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (rsel_q)
      RS_INDEX: rdata_o[DATA_W-1 -: CH_W] = ridx_q;
      RS_PAL: begin
        case (rseq_q)
          SEQ_GRN: rdata_o[DATA_W-1 -: CH_W] = pal_q_i[1];
          SEQ_BLU: rdata_o[DATA_W-1 -: CH_W] = pal_q_i[2];
          default: rdata_o[DATA_W-1 -: CH_W] = pal_q_i[0];
        endcase
      end
      RS_GAM:  rdata_o[DATA_W-1 -: CH_W] = gam_q_i[0];
      RS_OVL:  rdata_o[DATA_W-1 -: CH_W] = rovl_q;
      default: rdata_o = '0;
    endcase
  end

  // R8: the channel step never leaves the three legal states
  p_seq_legal_r8: assert property (@(posedge clk) disable iff (rst)
    seq_q inside {SEQ_RED, SEQ_GRN, SEQ_BLU});

  // R7: an index write loads the index from the top data byte and rewinds the step
  p_index_load_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_i && ofs_i == OFS_INDEX) |=>
      (idx_o == $past(wdata_i[DATA_W-1 -: CH_W]) && seq_q == SEQ_RED));

  // R8: a blue access advances the index by one modulo the table size
  p_index_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    ((wr_i || rd_i) && (ofs_i == OFS_PAL || ofs_i == OFS_OVL) && seq_q == SEQ_BLU) |=>
      (idx_o == CH_W'($past(idx_o) + 1'b1)));

  // R11: read data is flagged exactly one clock after an accepted read
  p_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !wr_i) |=> rvalid_o);
  p_rvalid_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !(rd_i && !wr_i) |=> !rvalid_o);

  // R10: the three gamma copies answer a register read identically
  p_gamma_copies_r10: assert property (@(posedge clk) disable iff (rst)
    (rvalid_o && rsel_q == RS_GAM) |->
      (gam_q_i[1] == gam_q_i[0] && gam_q_i[2] == gam_q_i[0]));

endmodule

// File: rtl/vlut_pixpipe.sv
// Two-stage pixel path. Stage one issues the table reads and holds the
// selector and colour bytes; stage two selects per channel and registers.
module vlut_pixpipe
  import vlut_pkg::*;
#(
  parameter int unsigned CH_W  = 8,
  localparam int unsigned PIX_W = NCH * CH_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [PIX_W-1:0]         in_word,
  output logic [NCH-1:0][CH_W-1:0] pal_addr_o,
  output logic [NCH-1:0][CH_W-1:0] gam_addr_o,
  input  logic [NCH-1:0][CH_W-1:0] pal_q_i,
  input  logic [NCH-1:0][CH_W-1:0] gam_q_i,
  output logic                     out_valid,
  output logic [NCH-1:0][CH_W-1:0] rgb_o
);

  visual_e                  in_vis;
  logic [NCH-1:0][CH_W-1:0] in_col;
  logic                     s1_valid;
  visual_e                  s1_vis;
  logic [NCH-1:0][CH_W-1:0] s1_col;
  logic [NCH-1:0][CH_W-1:0] mix;

  assign in_vis = visual_e'(in_word[PIX_W-1 -: 2]);
  assign in_col = in_word[NCH*CH_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // Indexed visual uses byte 0 for every channel; direct uses its own byte.
    assign pal_addr_o[c] = (in_vis == VIS_DIRECT) ? in_col[c] : in_col[0];
    assign gam_addr_o[c] = in_col[c];

    always_comb begin
      case (s1_vis)
        VIS_GAMMA: mix[c] = gam_q_i[c];
        VIS_RAW:   mix[c] = s1_col[c];
        default:   mix[c] = pal_q_i[c];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_vis    <= VIS_PSEUDO;
      s1_col    <= '0;
      out_valid <= 1'b0;
      rgb_o     <= '0;
    end else begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
      if (in_valid) begin
        s1_vis <= in_vis;
        s1_col <= in_col;
      end
      if (s1_valid) begin
        rgb_o <= mix;
      end
    end
  end

  // R6: each input pixel appears two clocks later
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  // R6: no output without an input two clocks earlier
  p_bubble_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
  // R4: raw visual passes the colour bytes through untouched
  p_raw_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word[PIX_W-1 -: 2] == 2'b11) |->
      ##2 (rgb_o == $past(in_word[NCH*CH_W-1:0], 2)));

endmodule

// File: rtl/visual_lut.sv
module visual_lut
  import vlut_pkg::*;
#(
  parameter int unsigned      CH_W      = 8,
  parameter int unsigned      DATA_W    = 32,
  parameter int unsigned      OVL_N     = 4,
  parameter logic [OVL_N-1:0] OVL_WHITE = 4'b0101,
  localparam int unsigned     PIX_W     = NCH * CH_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_word_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [OFS_W-1:0]  reg_ofs_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              rgb_valid_o,
  output logic [CH_W-1:0]   red_o,
  output logic [CH_W-1:0]   green_o,
  output logic [CH_W-1:0]   blue_o
);

  logic [CH_W-1:0]          idx;
  logic [CH_W-1:0]          wbyte;
  logic [NCH-1:0]           pal_we;
  logic                     gam_we;
  logic                     tab_re;
  logic [NCH-1:0][CH_W-1:0] pal_qa, pal_qb;
  logic [NCH-1:0][CH_W-1:0] gam_qa, gam_qb;
  logic [NCH-1:0][CH_W-1:0] pal_addr, gam_addr;
  logic [NCH-1:0][CH_W-1:0] rgb;

  vlut_regif #(
    .CH_W(CH_W), .DATA_W(DATA_W), .OVL_N(OVL_N), .OVL_WHITE(OVL_WHITE)
  ) u_regif (
    .clk(clk), .rst(rst),
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .ofs_i(reg_ofs_i), .wdata_i(reg_wdata_i),
    .idx_o(idx), .wbyte_o(wbyte), .pal_we_o(pal_we), .gam_we_o(gam_we),
    .tab_re_o(tab_re), .pal_q_i(pal_qa), .gam_q_i(gam_qa),
    .rdata_o(reg_rdata_o), .rvalid_o(reg_rvalid_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_tab
    vlut_table #(.IDX_W(CH_W), .W(CH_W), .IDENT_DEF(1'b0)) u_pal (
      .clk(clk), .rst(rst), .we(pal_we[c]), .a_addr(idx), .wdata(wbyte),
      .a_re(tab_re), .a_q(pal_qa[c]), .b_addr(pal_addr[c]), .b_q(pal_qb[c])
    );
    vlut_table #(.IDX_W(CH_W), .W(CH_W), .IDENT_DEF(1'b1)) u_gam (
      .clk(clk), .rst(rst), .we(gam_we), .a_addr(idx), .wdata(wbyte),
      .a_re(tab_re), .a_q(gam_qa[c]), .b_addr(gam_addr[c]), .b_q(gam_qb[c])
    );
  end

  vlut_pixpipe #(.CH_W(CH_W)) u_pipe (
    .clk(clk), .rst(rst),
    .in_valid(pix_valid_i), .in_word(pix_word_i),
    .pal_addr_o(pal_addr), .gam_addr_o(gam_addr),
    .pal_q_i(pal_qb), .gam_q_i(gam_qb),
    .out_valid(rgb_valid_o), .rgb_o(rgb)
  );

  assign red_o   = rgb[0];
  assign green_o = rgb[1];
  assign blue_o  = rgb[2];

endmodule

// File: tb/visual_lut_test.sv
module visual_lut_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_valid_i = 1'b0;
  logic [25:0] pix_word_i = '0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [3:0]  reg_ofs_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        reg_rvalid_o;
  logic        rgb_valid_o;
  logic [7:0]  red_o, green_o, blue_o;

  visual_lut uut (
    .clk(clk), .rst(rst),
    .pix_valid_i(pix_valid_i), .pix_word_i(pix_word_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_ofs_i(reg_ofs_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .reg_rvalid_o(reg_rvalid_o), .rgb_valid_o(rgb_valid_o),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R13";

  // Behavioural model state
  int pal [3][256];
  int ovl [3][4];
  int gam [256];
  int m_idx, m_seq;
  bit st1_v, st2_v;
  int st1_r, st1_g, st1_b, st2_r, st2_g, st2_b;
  bit exp_rv;
  int exp_rd;

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      pal[0][i] = 0; pal[1][i] = 0; pal[2][i] = 0; gam[i] = i;
    end
    pal[0][255] = 255; pal[1][255] = 255; pal[2][255] = 255;
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 3; c++) ovl[c][k] = (k % 2 == 0) ? 255 : 0;
    end
    m_idx = 0; m_seq = 0;
  endtask

  task automatic advance();
    if (m_seq == 2) begin
      m_seq = 0; m_idx = (m_idx + 1) % 256;
    end else begin
      m_seq++;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
      st1_v = 0; st2_v = 0; exp_rv = 0;
    end else begin
      int b0, b1, b2, md, d;
      st2_v = st1_v; st2_r = st1_r; st2_g = st1_g; st2_b = st1_b;
      st1_v = pix_valid_i;
      if (pix_valid_i) begin
        b0 = pix_word_i[7:0]; b1 = pix_word_i[15:8]; b2 = pix_word_i[23:16];
        md = pix_word_i[25:24];
        case (md)
          0: begin st1_r = pal[0][b0]; st1_g = pal[1][b0]; st1_b = pal[2][b0]; end
          1: begin st1_r = pal[0][b0]; st1_g = pal[1][b1]; st1_b = pal[2][b2]; end
          2: begin st1_r = gam[b0]; st1_g = gam[b1]; st1_b = gam[b2]; end
          default: begin st1_r = b0; st1_g = b1; st1_b = b2; end
        endcase
      end
      exp_rv = reg_rd_i && !reg_wr_i;
      d = reg_wdata_i[31:24];
      if (exp_rv) begin
        case (reg_ofs_i)
          4'd0:  exp_rd = m_idx << 24;
          4'd4:  begin exp_rd = pal[m_seq][m_idx] << 24; advance(); end
          4'd12: begin exp_rd = ovl[m_seq][m_idx % 4] << 24; advance(); end
          4'd8:  begin exp_rd = gam[m_idx] << 24; m_idx = (m_idx + 1) % 256; end
          default: exp_rd = 0;
        endcase
      end
      if (reg_wr_i) begin
        case (reg_ofs_i)
          4'd0:  begin m_idx = d; m_seq = 0; end
          4'd4:  begin pal[m_seq][m_idx] = d; advance(); end
          4'd12: begin ovl[m_seq][m_idx % 4] = d; advance(); end
          4'd8:  begin gam[m_idx] = d; m_idx = (m_idx + 1) % 256; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // Compare away from the active edge, once per clock
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      chk(rgb_valid_o === st2_v, "rgb_valid", int'(rgb_valid_o), int'(st2_v));
      if (st2_v) begin
        chk(red_o === 8'(st2_r), "red", int'(red_o), st2_r);
        chk(green_o === 8'(st2_g), "green", int'(green_o), st2_g);
        chk(blue_o === 8'(st2_b), "blue", int'(blue_o), st2_b);
      end
      chk(reg_rvalid_o === exp_rv, "rvalid", int'(reg_rvalid_o), int'(exp_rv));
      if (exp_rv) chk(reg_rdata_o === 32'(exp_rd), "rdata", int'(reg_rdata_o), exp_rd);
    end
  end

  task automatic cyc(input bit pv, input logic [25:0] pw, input bit w, input bit r,
                     input logic [3:0] o, input logic [31:0] d);
    @(negedge clk);
    pix_valid_i = pv; pix_word_i = pw;
    reg_wr_i = w; reg_rd_i = r; reg_ofs_i = o; reg_wdata_i = d;
  endtask

  task automatic wreg(input logic [3:0] o, input logic [7:0] b);
    cyc(0, '0, 1, 0, o, {b, 24'h00_5A3C});
  endtask
  task automatic rreg(input logic [3:0] o);
    cyc(0, '0, 0, 1, o, '0);
  endtask
  task automatic pix(input logic [1:0] m, input logic [7:0] c2, input logic [7:0] c1,
                     input logic [7:0] c0);
    cyc(1, {m, c2, c1, c0}, 0, 0, '0, '0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset contents, index and step
    cur_req = "R13";
    idle(2);
    rreg(4'd0); rreg(4'd4); rreg(4'd4); rreg(4'd4);
    wreg(4'd0, 8'hFF); rreg(4'd4); rreg(4'd4); rreg(4'd4); rreg(4'd0);
    for (int i = 0; i < 12; i++) rreg(4'd12);
    wreg(4'd0, 8'h00);
    pix(2'b00, 8'h00, 8'h00, 8'hFF); pix(2'b00, 8'h00, 8'h00, 8'h00);
    idle(3);

    // Index load, including a rewind in the middle of a sequence
    cur_req = "R7";
    wreg(4'd0, 8'h10); rreg(4'd0);
    wreg(4'd4, 8'h11); wreg(4'd0, 8'h10);
    wreg(4'd4, 8'hA1); wreg(4'd4, 8'hA2); wreg(4'd4, 8'hA3); rreg(4'd0);
    wreg(4'd0, 8'h10); rreg(4'd4); rreg(4'd4); rreg(4'd4); rreg(4'd0);
    idle(2);

    // Palette sequence and wrap from 255
    cur_req = "R8";
    wreg(4'd0, 8'h20);
    for (int i = 0; i < 9; i++) wreg(4'd4, 8'(8'h30 + i * 7));
    rreg(4'd0);
    wreg(4'd0, 8'hFE);
    for (int i = 0; i < 6; i++) wreg(4'd4, 8'(8'hC0 + i));
    rreg(4'd0);
    for (int i = 0; i < 3; i++) wreg(4'd4, 8'(8'h90 + i));
    wreg(4'd0, 8'hFE);
    for (int i = 0; i < 9; i++) rreg(4'd4);
    idle(2);

    cur_req = "R11";
    wreg(4'd0, 8'h20);
    for (int i = 0; i < 6; i++) rreg(4'd4);
    rreg(4'd0); idle(4); rreg(4'd8); idle(2);

    cur_req = "R2";
    pix(2'b00, 8'h00, 8'h00, 8'h20); pix(2'b00, 8'hFF, 8'h55, 8'h21);
    pix(2'b00, 8'h00, 8'h00, 8'h22); pix(2'b00, 8'h00, 8'h00, 8'hFE);
    pix(2'b00, 8'h00, 8'h00, 8'hFF); pix(2'b00, 8'h12, 8'h34, 8'h00);
    idle(3);

    cur_req = "R3";
    pix(2'b01, 8'h22, 8'h21, 8'h20); pix(2'b01, 8'h20, 8'h21, 8'h22);
    pix(2'b01, 8'hFF, 8'hFE, 8'h10); pix(2'b01, 8'h00, 8'hFF, 8'hFE);
    idle(3);

    // Gamma defaults, loading and read-back
    cur_req = "R5";
    pix(2'b10, 8'h40, 8'h41, 8'h42); pix(2'b10, 8'hFF, 8'h00, 8'h80);
    cur_req = "R10";
    wreg(4'd0, 8'h40);
    wreg(4'd4, 8'hEE);
    wreg(4'd8, 8'h07); wreg(4'd8, 8'h17); wreg(4'd8, 8'h27);
    wreg(4'd4, 8'hDD); rreg(4'd0);
    wreg(4'd0, 8'h40); rreg(4'd8); rreg(4'd8); rreg(4'd8); rreg(4'd0);
    cur_req = "R5";
    pix(2'b10, 8'h42, 8'h41, 8'h40); pix(2'b10, 8'h40, 8'h43, 8'h42);
    idle(3);

    cur_req = "R4";
    pix(2'b11, 8'h01, 8'h02, 8'h03); pix(2'b11, 8'hFF, 8'h00, 8'hA5);
    cur_req = "R1";
    pix(2'b11, 8'hC3, 8'h3C, 8'h81); pix(2'b01, 8'hFF, 8'h21, 8'h20);
    pix(2'b00, 8'hFF, 8'hFF, 8'h20);
    idle(3);

    // Overlay entries alias through the low index bits
    cur_req = "R9";
    wreg(4'd0, 8'h05);
    wreg(4'd12, 8'h61); wreg(4'd12, 8'h62); wreg(4'd12, 8'h63);
    wreg(4'd12, 8'h71); rreg(4'd0);
    wreg(4'd0, 8'h01); rreg(4'd12); rreg(4'd12); rreg(4'd12);
    rreg(4'd12); rreg(4'd12); rreg(4'd12);
    wreg(4'd0, 8'h05); rreg(4'd4); rreg(4'd4); rreg(4'd4);
    pix(2'b00, 8'h00, 8'h00, 8'h05);
    idle(3);

    // Unknown offsets
    cur_req = "R12";
    wreg(4'd0, 8'h20);
    wreg(4'd5, 8'h99); wreg(4'd14, 8'h98); wreg(4'd2, 8'h97); wreg(4'd15, 8'h96);
    rreg(4'd5); rreg(4'd14); rreg(4'd3); rreg(4'd0);
    rreg(4'd4); rreg(4'd4); rreg(4'd4);
    pix(2'b00, 8'h00, 8'h00, 8'h20);
    idle(3);

    // Write and lookup of the same entry in one clock
    cur_req = "R14";
    wreg(4'd0, 8'h33);
    cyc(1, {2'b00, 24'h000033}, 1, 0, 4'd4, 32'h5500_0000);
    cyc(1, {2'b00, 24'h000033}, 0, 0, 4'd0, 32'h0);
    wreg(4'd0, 8'h50);
    cyc(1, {2'b10, 24'h505050}, 1, 0, 4'd8, 32'h0900_0000);
    cyc(1, {2'b10, 24'h505050}, 0, 0, 4'd0, 32'h0);
    idle(3);

    // Throughput: back-to-back pixels and gaps
    cur_req = "R6";
    for (int i = 0; i < 40; i++) begin
      pix(2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end
    idle(1); pix(2'b11, 8'h01, 8'h02, 8'h03); idle(1);
    pix(2'b00, 8'h00, 8'h00, 8'h20); pix(2'b01, 8'h22, 8'h21, 8'h20);
    idle(4);

    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] o;
      int sel;
      bit w, r;
      sel = $urandom_range(0, 9);
      o = (sel < 2) ? 4'd0 : (sel < 5) ? 4'd4 : (sel < 7) ? 4'd8 : (sel < 9) ? 4'd12 : 4'd6;
      w = ($urandom_range(0, 3) == 0);
      r = ($urandom_range(0, 2) == 0);
      cyc($urandom_range(0, 1) == 1, 26'($urandom), w, r, o, $urandom);
    end
    idle(4);

    // A second reset restores written entries
    cur_req = "R13";
    @(negedge clk); rst = 1'b1;
    pix_valid_i = 0; reg_wr_i = 0; reg_rd_i = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    idle(1);
    pix(2'b00, 8'h00, 8'h00, 8'h20); pix(2'b01, 8'h22, 8'hFF, 8'h10);
    pix(2'b10, 8'h42, 8'h41, 8'h40);
    rreg(4'd0);
    wreg(4'd0, 8'h01);
    for (int i = 0; i < 9; i++) rreg(4'd12);
    idle(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule